// File: doc/BRIEF.md
# Segmented Fully-Associative Cache Lookup Core

This block holds the tags, valid bits and data lines of a small 4 KB cache. The cache is split into four 1 KB segments, and each segment has 64 rows of four 32-bit words. Two address bits pick the segment. The upper address bits then form a 26-bit tag. That tag is compared against all 64 stored tags of the chosen segment in the same cycle, so each segment is fully associative with 64 ways. A matching valid row enables its line for a single-word read or write.

Requests use a valid/ready handshake. One cycle after a request is accepted, the block returns a registered response. The response carries the hit flag, the read word, and the routing a miss needs: external memory, the write buffer, or a line allocation. Line fills come in on a separate port as four word writes in order. The row to fill is picked outside this block and arrives on `fill_row`. A flush input invalidates every row in one cycle.

Top module: `seg_cam_cache`

## Requirements
- R1: The word address is split as follows. Bits 31:6 are the tag, bits 5:4 pick the segment and bits 3:2 pick the word. Only rows of the selected segment take part in a match, so a tag stored in a different segment never hits.
- R2: A request is accepted when `req_valid` and `req_ready` are both high. In the next cycle `resp_valid` is high, and it is low in the cycle after a cycle with no acceptance. A read hit returns the addressed word of the matching row on `resp_rdata`. Writes and misses return zero.
- R3: After reset no row is valid, and a row that is not valid never reports a hit.
- R4: A read miss sets `resp_ext`. It also sets `resp_alloc` only when `req_cachable` is high. A hit never sets `resp_ext`, `resp_wbuf` or `resp_alloc`.
- R5: A write miss never allocates a line and leaves all stored data unchanged. With `req_buffered` high it sets `resp_wbuf` and not `resp_ext`; otherwise it sets `resp_ext` and not `resp_wbuf`.
- R6: A write hit replaces only the addressed word of the matching row.
- R7: A read is always ready. A write is sequential when its address equals the previously accepted address plus 4. A sequential write is accepted in its first cycle. Any other write sees `req_ready` low for one cycle and high in the next cycle, as long as `req_valid` stays high.
- R8: A fill beat with word index 0 stores the tag in row `fill_row` of the addressed segment and clears that row's valid bit. A beat with word index 3 sets the valid bit. Every beat writes its data word into that row. A lookup in the same cycle as a fill beat sees the state from before the beat.
- R9: `flush` clears every valid bit in one cycle. A lookup in the flush cycle still sees the contents from before the flush. Flush takes precedence over a fill beat that would set a valid bit.
- R10: If several valid rows of a segment hold the same tag, the lowest-numbered row supplies the data and `resp_multi` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cachable | input | 1 | Read targets a cachable region |
| req_buffered | input | 1 | Write may be absorbed by the write buffer |
| req_addr | input | 32 | Byte address of the request |
| req_wdata | input | 32 | Write data |
| fill_valid | input | 1 | Fill beat present |
| fill_addr | input | 32 | Address of the fill beat (tag, segment, word) |
| fill_row | input | 6 | Victim row to fill |
| fill_data | input | 32 | Fill data word |
| flush | input | 1 | Invalidate all rows |
| resp_valid | output | 1 | Response for the request accepted last cycle |
| resp_hit | output | 1 | Lookup matched a valid row |
| resp_multi | output | 1 | More than one row matched |
| resp_ext | output | 1 | Miss must go to external memory |
| resp_wbuf | output | 1 | Write miss goes to the write buffer |
| resp_alloc | output | 1 | Read miss allocates a line |
| resp_rdata | output | 32 | Read data |

## Verification
The functions most likely to collide are a lookup and a state change to the same segment. These state changes are a flush, or a fill beat that writes the row being looked up. The bench drives `flush` high in the same cycle as a read to a row that is present and expects a hit. It then expects a miss on the next read. In another test it refills a row with a new tag while reading the old tag in that same cycle, and expects the old data. A behavioural model, updated after each edge, judges both cases. It also places a flush on the final beat of a fill and expects that row to stay invalid.

// File: rtl/seg_cam_pkg.sv
// Shared defaults and the response flag record for the segmented cache core.
// Assumes word-aligned 32-bit accesses.
package seg_cam_pkg;
    localparam int ADDR_W_DEF = 32;
    localparam int DATA_W_DEF = 32;
    localparam int SEGS_DEF   = 4;
    localparam int ROWS_DEF   = 64;
    localparam int WORDS_DEF  = 4;

    typedef struct packed {
        logic hit;
        logic multi;
        logic ext;
        logic wbuf;
        logic alloc;
    } resp_flags_t;
endpackage

// File: rtl/seg_cam_match.sv
// Parallel tag compare for one segment: one comparator per row.
// Assumes the caller has already muxed in the selected segment's tags and valids.
module seg_cam_match #(
    parameter int ROWS  = 64,
    parameter int TAG_W = 26
) (
    input  logic [ROWS-1:0][TAG_W-1:0] row_tag,
    input  logic [ROWS-1:0]            row_valid,
    input  logic [TAG_W-1:0]           probe_tag,
    output logic [ROWS-1:0]            match
);
    // One comparator per row; an invalid row is masked.
    for (genvar g = 0; g < ROWS; g++) begin : g_row
        assign match[g] = row_valid[g] && (row_tag[g] == probe_tag);
    end
endmodule

// File: rtl/seg_cam_prio.sv
// Reduces the row match vector to a row index, an any-match flag and a multi-match flag.
// The lowest-numbered matching row wins.
module seg_cam_prio #(
    parameter int ROWS  = 64,
    parameter int IDX_W = 6
) (
    input  logic [ROWS-1:0]  match,
    output logic [IDX_W-1:0] idx,
    output logic             any,
    output logic             multi
);
    // Scan from the top down so the lowest set row is written last.
    always_comb begin
        idx = '0;
        for (int i = ROWS - 1; i >= 0; i--) begin
            if (match[i]) idx = IDX_W'(i);
        end
        any   = |match;
        multi = (match & (match - ROWS'(1))) != '0;
    end
endmodule

// File: rtl/seg_cam_wseq.sv
// Request acceptance: reads are always taken; a write that does not follow the
// last accepted address by one word is held off for a single cycle.
// Assumes the requester keeps req_valid high until it is accepted.
module seg_cam_wseq #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              accept
);
    logic [ADDR_W-1:0] last_q;
    logic              last_ok_q;
    logic              wait_q;
    logic              seq;

    // Ready and accept decode from the sequence state.
    always_comb begin
        seq       = last_ok_q && (req_addr == last_q + ADDR_W'(4));
        req_ready = !(req_valid && req_write && !seq && !wait_q);
        accept    = req_valid && req_ready;
    end

    // Track the last accepted address and the one-cycle hold-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q    <= '0;
            last_ok_q <= 1'b0;
            wait_q    <= 1'b0;
        end else begin
            if (accept) begin
                last_q    <= req_addr;
                last_ok_q <= 1'b1;
            end
            wait_q <= req_valid && !req_ready;
        end
    end
endmodule

// File: rtl/seg_cam_cache.sv
// Lookup and storage core of a segmented cache. Each segment is a fully
// associative array of tagged lines. Lookups are registered; fills arrive as
// word beats in order 0..WORDS-1 into an externally chosen row; flush
// invalidates everything. Tags, valids and data are plain registers.
module seg_cam_cache
    import seg_cam_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF,
    parameter int SEGS   = SEGS_DEF,
    parameter int ROWS   = ROWS_DEF,
    parameter int WORDS  = WORDS_DEF,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_cachable,
    input  logic              req_buffered,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [ROW_W-1:0]  fill_row,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              flush,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic              resp_multi,
    output logic              resp_ext,
    output logic              resp_wbuf,
    output logic              resp_alloc,
    output logic [DATA_W-1:0] resp_rdata
);
    localparam int OFF_W   = $clog2(DATA_W / 8);
    localparam int WORD_W  = $clog2(WORDS);
    localparam int SEG_W   = $clog2(SEGS);
    localparam int WORD_LO = OFF_W;
    localparam int SEG_LO  = OFF_W + WORD_W;
    localparam int TAG_LO  = SEG_LO + SEG_W;
    localparam int TAG_W   = ADDR_W - TAG_LO;

    logic [DATA_W-1:0]                       line_mem [SEGS][ROWS][WORDS];
    logic [SEGS-1:0][ROWS-1:0][TAG_W-1:0]    tag_mem;
    logic [SEGS-1:0][ROWS-1:0]               vld_q;

    logic [SEG_W-1:0]  req_seg, fill_seg;
    logic [WORD_W-1:0] req_word, fill_word;
    logic [TAG_W-1:0]  req_tag, fill_tag;
    logic [ROWS-1:0]   row_match;
    logic [ROW_W-1:0]  hit_idx;
    logic              hit_any, hit_multi, acc;
    resp_flags_t       flags_d, flags_q;
    logic [DATA_W-1:0] rdata_q;

    // Address field extraction for the request and fill paths.
    always_comb begin
        req_seg   = req_addr[SEG_LO +: SEG_W];
        req_word  = req_addr[WORD_LO +: WORD_W];
        req_tag   = req_addr[ADDR_W-1:TAG_LO];
        fill_seg  = fill_addr[SEG_LO +: SEG_W];
        fill_word = fill_addr[WORD_LO +: WORD_W];
        fill_tag  = fill_addr[ADDR_W-1:TAG_LO];
    end

    seg_cam_match #(.ROWS(ROWS), .TAG_W(TAG_W)) u_match (
        .row_tag   (tag_mem[req_seg]),
        .row_valid (vld_q[req_seg]),
        .probe_tag (req_tag),
        .match     (row_match)
    );

    seg_cam_prio #(.ROWS(ROWS), .IDX_W(ROW_W)) u_prio (
        .match (row_match),
        .idx   (hit_idx),
        .any   (hit_any),
        .multi (hit_multi)
    );

    seg_cam_wseq #(.ADDR_W(ADDR_W)) u_wseq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_ready (req_ready),
        .accept    (acc)
    );

    // Miss routing and allocation decision for the current lookup.
    always_comb begin
        flags_d.hit   = hit_any;
        flags_d.multi = hit_multi;
        flags_d.ext   = !hit_any && !(req_write && req_buffered);
        flags_d.wbuf  = !hit_any && req_write && req_buffered;
        flags_d.alloc = !hit_any && !req_write && req_cachable;
    end

    // Data line writes: write hits first, fill beats override.
    always_ff @(posedge clk) begin
        if (acc && req_write && hit_any)
            line_mem[req_seg][hit_idx][req_word] <= req_wdata;
        if (fill_valid)
            line_mem[fill_seg][fill_row][fill_word] <= fill_data;
    end

    // Tag capture on the first fill beat.
    always_ff @(posedge clk) begin
        if (fill_valid && fill_word == '0)
            tag_mem[fill_seg][fill_row] <= fill_tag;
    end

    // Valid bits: reset and flush clear all; fill beats clear or set one row.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            vld_q <= '0;
        end else if (fill_valid) begin
            if (fill_word == '0)
                vld_q[fill_seg][fill_row] <= 1'b0;
            else if (fill_word == WORD_W'(WORDS - 1))
                vld_q[fill_seg][fill_row] <= 1'b1;
        end
    end

    // Registered response, updated on each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            flags_q    <= '0;
            rdata_q    <= '0;
        end else begin
            resp_valid <= acc;
            if (acc) begin
                flags_q <= flags_d;
                rdata_q <= (!req_write && hit_any) ? line_mem[req_seg][hit_idx][req_word] : '0;
            end
        end
    end

    assign resp_hit   = flags_q.hit;
    assign resp_multi = flags_q.multi;
    assign resp_ext   = flags_q.ext;
    assign resp_wbuf  = flags_q.wbuf;
    assign resp_alloc = flags_q.alloc;
    assign resp_rdata = rdata_q;
endmodule

// File: rtl/seg_cam_cache_chk.sv
// Protocol and response checks for seg_cam_cache, attached by bind.
module seg_cam_cache_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic req_write,
    input logic flush,
    input logic resp_valid,
    input logic resp_hit,
    input logic resp_multi,
    input logic resp_ext,
    input logic resp_wbuf,
    input logic resp_alloc
);
    assert_resp_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> resp_valid);

    assert_no_resp_without_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> !resp_valid);

    assert_hit_no_route_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_hit) |-> !(resp_ext || resp_wbuf || resp_alloc));

    assert_alloc_implies_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_alloc) |-> resp_ext);

    assert_miss_one_route_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_hit) |-> (resp_ext != resp_wbuf));

    assert_read_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |-> req_ready);

    assert_stall_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_ready) ##1 req_valid |-> req_ready);

    assert_flush_then_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush ##1 (req_valid && req_ready && !req_write) |=> !resp_hit);

    assert_multi_is_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_multi) |-> resp_hit);
endmodule

bind seg_cam_cache seg_cam_cache_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .flush      (flush),
    .resp_valid (resp_valid),
    .resp_hit   (resp_hit),
    .resp_multi (resp_multi),
    .resp_ext   (resp_ext),
    .resp_wbuf  (resp_wbuf),
    .resp_alloc (resp_alloc)
);

// File: tb/seg_cam_cache_test.sv
// Bench: behavioural model stepped once per clock and compared against the outputs.
module seg_cam_cache_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write, req_cachable, req_buffered;
    logic        req_ready;
    logic [31:0] req_addr, req_wdata;
    logic        fill_valid;
    logic [31:0] fill_addr, fill_data;
    logic [5:0]  fill_row;
    logic        flush;
    logic        resp_valid, resp_hit, resp_multi, resp_ext, resp_wbuf, resp_alloc;
    logic [31:0] resp_rdata;

    int n_cmp = 0;
    int n_bad = 0;

    // Behavioural model state.
    logic [31:0] m_data [4][64][4];
    logic [25:0] m_tag  [4][64];
    bit          m_vld  [4][64];
    logic [31:0] m_last;
    bit          m_last_ok, m_wait, m_acc;

    always #(CLK_PERIOD / 2) clk = ~clk;

    seg_cam_cache uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_cachable(req_cachable), .req_buffered(req_buffered),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_row(fill_row),
        .fill_data(fill_data), .flush(flush),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_multi(resp_multi),
        .resp_ext(resp_ext), .resp_wbuf(resp_wbuf), .resp_alloc(resp_alloc),
        .resp_rdata(resp_rdata)
    );

    function automatic logic [31:0] mk(input logic [25:0] tag, input logic [1:0] seg, input logic [1:0] wd);
        return {tag, seg, wd, 2'b00};
    endfunction

    task automatic chk(input string r, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
        end
    endtask

    // One clock: check ready, step the model, then compare the registered response.
    task automatic cyc(input string r);
        logic [1:0]  seg, wd, fseg, fwd;
        logic [25:0] tag;
        int          cnt, first;
        bit          seq, rdy, e_hit;
        logic [31:0] e_rd;
        #1;
        seg = req_addr[5:4]; wd = req_addr[3:2]; tag = req_addr[31:6];
        seq = m_last_ok && (req_addr == m_last + 32'd4);
        rdy = !(req_valid && req_write && !seq && !m_wait);
        chk("R7", "req_ready", {31'd0, req_ready}, {31'd0, rdy});
        m_acc = req_valid && rdy;
        cnt = 0; first = 0;
        for (int r2 = 0; r2 < 64; r2++) begin
            if (m_vld[seg][r2] && m_tag[seg][r2] == tag) begin
                if (cnt == 0) first = r2;
                cnt++;
            end
        end
        e_hit = cnt > 0;
        e_rd  = (!req_write && e_hit) ? m_data[seg][first][wd] : 32'd0;
        if (m_acc && req_write && e_hit) m_data[seg][first][wd] = req_wdata;
        if (fill_valid) begin
            fseg = fill_addr[5:4]; fwd = fill_addr[3:2];
            m_data[fseg][fill_row][fwd] = fill_data;
            if (fwd == 2'd0) begin
                m_tag[fseg][fill_row] = fill_addr[31:6];
                m_vld[fseg][fill_row] = 1'b0;
            end else if (fwd == 2'd3) begin
                m_vld[fseg][fill_row] = 1'b1;
            end
        end
        if (flush) for (int s = 0; s < 4; s++) for (int q = 0; q < 64; q++) m_vld[s][q] = 1'b0;
        if (m_acc) begin m_last = req_addr; m_last_ok = 1'b1; end
        m_wait = req_valid && !rdy;
        @(posedge clk);
        @(negedge clk);
        chk("R2", "resp_valid", {31'd0, resp_valid}, {31'd0, m_acc});
        if (m_acc) begin
            chk(r, "resp_hit",   {31'd0, resp_hit},   {31'd0, e_hit});
            chk(r, "resp_multi", {31'd0, resp_multi}, {31'd0, cnt > 1});
            chk(r, "resp_ext",   {31'd0, resp_ext},   {31'd0, !e_hit && !(req_write && req_buffered)});
            chk(r, "resp_wbuf",  {31'd0, resp_wbuf},  {31'd0, !e_hit && req_write && req_buffered});
            chk(r, "resp_alloc", {31'd0, resp_alloc}, {31'd0, !e_hit && !req_write && req_cachable});
            chk(r, "resp_rdata", resp_rdata, e_rd);
        end
    endtask

    task automatic idle_in();
        req_valid = 0; req_write = 0; req_cachable = 0; req_buffered = 0;
        req_addr = 0; req_wdata = 0; fill_valid = 0; fill_addr = 0;
        fill_row = 0; fill_data = 0; flush = 0;
    endtask

    task automatic rd(input logic [31:0] a, input bit cach, input string r);
        req_valid = 1; req_write = 0; req_addr = a; req_cachable = cach;
        cyc(r);
        req_valid = 0;
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d, input bit buff, input int exp_cycles, input string r);
        int n = 0;
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; req_buffered = buff;
        do begin cyc(r); n++; end while (!m_acc && n < 4);
        chk(r, "write cycles", n, exp_cycles);
        req_valid = 0; req_write = 0; req_buffered = 0;
    endtask

    task automatic fbeat(input logic [25:0] tag, input logic [1:0] seg, input logic [5:0] row,
                         input logic [1:0] wd, input logic [31:0] d, input string r);
        fill_valid = 1; fill_addr = mk(tag, seg, wd); fill_row = row; fill_data = d;
        cyc(r);
        fill_valid = 0;
    endtask

    task automatic fline(input logic [25:0] tag, input logic [1:0] seg, input logic [5:0] row,
                         input logic [31:0] base, input string r);
        for (int w = 0; w < 4; w++) fbeat(tag, seg, row, 2'(w), base + 32'(w), r);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        idle_in();
        rst_n = 0;
        m_last = 0; m_last_ok = 0; m_wait = 0; m_acc = 0;
        for (int s = 0; s < 4; s++) for (int q = 0; q < 64; q++) m_vld[s][q] = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2", "resp_valid in reset", {31'd0, resp_valid}, 32'd0);
        rst_n = 1;

        // R3: nothing hits after reset; cachable read allocates.
        rd(mk(26'h5, 2'd1, 2'd0), 1, "R3");
        // R8: fill in progress does not yet hit, completes on last beat.
        fbeat(26'h5, 2'd1, 6'd7, 2'd0, 32'hA000, "R8");
        fbeat(26'h5, 2'd1, 6'd7, 2'd1, 32'hA001, "R8");
        fbeat(26'h5, 2'd1, 6'd7, 2'd2, 32'hA002, "R8");
        rd(mk(26'h5, 2'd1, 2'd2), 1, "R8");
        fbeat(26'h5, 2'd1, 6'd7, 2'd3, 32'hA003, "R8");
        for (int w = 0; w < 4; w++) rd(mk(26'h5, 2'd1, 2'(w)), 1, "R2");
        // R1: same tag in another segment, other tag same segment.
        rd(mk(26'h5, 2'd2, 2'd0), 1, "R1");
        rd(mk(26'h6, 2'd1, 2'd0), 1, "R1");
        // R4: non-cachable read miss goes external without allocation.
        rd(mk(26'h6, 2'd1, 2'd1), 0, "R4");
        // R7/R6: non-sequential write stalls, sequential write does not.
        wr(mk(26'h5, 2'd1, 2'd1), 32'h1111, 0, 2, "R7");
        wr(mk(26'h5, 2'd1, 2'd2), 32'h2222, 0, 1, "R7");
        for (int w = 0; w < 4; w++) rd(mk(26'h5, 2'd1, 2'(w)), 1, "R6");
        // R5: write misses, buffered and not; no allocation follows.
        wr(mk(26'h30, 2'd0, 2'd0), 32'h3333, 1, 2, "R5");
        wr(mk(26'h31, 2'd0, 2'd0), 32'h4444, 0, 2, "R5");
        rd(mk(26'h30, 2'd0, 2'd0), 1, "R5");
        // R10: duplicate tags in one segment, lowest row wins.
        fline(26'h9, 2'd3, 6'd40, 32'hB000, "R10");
        rd(mk(26'h9, 2'd3, 2'd1), 1, "R10");
        fline(26'h9, 2'd3, 6'd12, 32'hC000, "R10");
        rd(mk(26'h9, 2'd3, 2'd1), 1, "R10");
        rd(mk(26'h9, 2'd3, 2'd3), 1, "R10");
        // R8: refill beat and lookup of the old tag in the same cycle.
        fline(26'hB, 2'd0, 6'd2, 32'hD000, "R8");
        req_valid = 1; req_write = 0; req_addr = mk(26'hB, 2'd0, 2'd0); req_cachable = 1;
        fbeat(26'hC, 2'd0, 6'd2, 2'd0, 32'hE000, "R8");
        req_valid = 0;
        rd(mk(26'hB, 2'd0, 2'd0), 1, "R8");
        // R9: flush together with a read hit, then everything misses.
        req_valid = 1; req_write = 0; req_addr = mk(26'h9, 2'd3, 2'd0); req_cachable = 1; flush = 1;
        cyc("R9");
        req_valid = 0; flush = 0;
        rd(mk(26'h9, 2'd3, 2'd0), 1, "R9");
        rd(mk(26'h5, 2'd1, 2'd0), 1, "R9");
        // R9: flush on the final fill beat wins over the valid set.
        fbeat(26'h7, 2'd2, 6'd5, 2'd0, 32'hF000, "R9");
        fbeat(26'h7, 2'd2, 6'd5, 2'd1, 32'hF001, "R9");
        fbeat(26'h7, 2'd2, 6'd5, 2'd2, 32'hF002, "R9");
        flush = 1;
        fbeat(26'h7, 2'd2, 6'd5, 2'd3, 32'hF003, "R9");
        flush = 0;
        rd(mk(26'h7, 2'd2, 2'd3), 1, "R9");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule